// File: doc/BRIEF.md
# Image Sensor Window Capture

This block follows the raster of a raw image sensor and keeps a small square patch of the picture in on-chip memory. It counts every pixel clock from a frame-start pulse, so it knows which line and which clock of the line each 12-bit sample belongs to. Each line opens with a fixed run of sync clocks that carry no picture. The active pixels follow. The samples whose position falls inside a programmable square window are written, unprocessed and still in their colour mosaic, into a dual-port RAM.

A second RAM port is driven by its own clock, so a display scanner can fetch the stored patch at any time. A done flag tells the consumer when the final window sample of the frame has landed. The block also produces the sensor's master clock by halving its reference clock.

With the default parameters a frame is 504 lines of 780 clocks each, and each line is 116 sync clocks followed by 664 pixels. The default window is 32 by 32 samples.

Top module: `sensor_window_grab`

## Requirements
- R1: `mclk_out` is 0 while `rst_n` is low. After reset it toggles on every rising edge of `ref_clk`, so its frequency is half the reference (5 MHz from 10 MHz).
- R2: A pixel-clock cycle with `fsync` high carries no sample and restarts the raster, even in the middle of a frame. The sample on the next cycle is line 0, clock 0.
- R3: Clocks 0 to HSYNC_CLKS-1 of every line are never stored. Active pixel column x is at line clock HSYNC_CLKS+x.
- R4: The sample at active column `ox+dx` of line `oy+dy` is stored at RAM address `dy*WIN + dx`, for 0 <= dx, dy < WIN. Here WIN is 2^WIN_LG, and `ox`/`oy` are the origin.
- R5: Samples outside the window are not written and do not alter any RAM word.
- R6: `org_x`/`org_y` are taken only on the `fsync` cycle. A change later in the frame does not move that frame's window.
- R7: `frame_done` is 0 after reset and is cleared by `fsync`. It goes to 1 on the clock edge that stores the last window sample (dx = dy = WIN-1), and it stays 1 until the next `fsync`.
- R8: After the last clock of the last line, nothing more is stored until the next `fsync`, however long the sample stream runs.
- R9: `rd_data` shows the RAM word at `rd_addr` one `rd_clk` rising edge after the address is applied, independently of the pixel clock.
- R10: A window placed in the bottom-right corner of the active image, whose last sample is the final clock of the frame, is captured completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the master clock divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_out | output | 1 | Sensor master clock, reference divided by two |
| pix_clk | input | 1 | Sensor pixel clock |
| fsync | input | 1 | Frame start pulse, one pixel clock wide |
| pix_data | input | SAMPLE_W (12) | Raw sensor sample |
| org_x | input | XW (10) | Window origin, active pixel column |
| org_y | input | RW (9) | Window origin, line |
| frame_done | output | 1 | Last window sample of the frame has been stored |
| rd_clk | input | 1 | Read port clock |
| rd_addr | input | 2*WIN_LG (10) | Read address, row*WIN + column |
| rd_data | output | SAMPLE_W (12) | Registered read data |

## Verification
A sample is written on the same pixel-clock edge at which it is presented, and `frame_done` is set on that same edge for the last window sample. The bench therefore checks the flag low at the falling edge just before that write and high at the falling edge just after it. Read data is due one `rd_clk` rising edge after the address. The scoreboard pushes each expected word when it applies the address and pops it at the following falling edge of `rd_clk`, so each comparison lands exactly one read cycle later. The divider output is compared at successive reference falling edges, where it must alternate.

// File: rtl/sensor_window_grab.sv
module sensor_window_grab #(
  parameter int LINE_CLKS   = 780,
  parameter int HSYNC_CLKS  = 116,
  parameter int FRAME_LINES = 504,
  parameter int SAMPLE_W    = 12,
  parameter int WIN_LG      = 5,
  localparam int CW  = $clog2(LINE_CLKS),
  localparam int RW  = $clog2(FRAME_LINES),
  localparam int XW  = $clog2(LINE_CLKS - HSYNC_CLKS),
  localparam int WIN = 1 << WIN_LG,
  localparam int AW  = 2 * WIN_LG
) (
  input  logic                ref_clk,
  input  logic                rst_n,
  output logic                mclk_out,
  input  logic                pix_clk,
  input  logic                fsync,
  input  logic [SAMPLE_W-1:0] pix_data,
  input  logic [XW-1:0]       org_x,
  input  logic [RW-1:0]       org_y,
  output logic                frame_done,
  input  logic                rd_clk,
  input  logic [AW-1:0]       rd_addr,
  output logic [SAMPLE_W-1:0] rd_data
);

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [XW-1:0] ox;
  logic [RW-1:0] oy;
  logic          armed;
  logic [CW:0]   ax, dx;
  logic [RW:0]   dy;
  logic          in_x, in_y, wr_en;
  logic [AW-1:0] wr_addr;
  logic [SAMPLE_W-1:0] mem [WIN*WIN];

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) mclk_out <= 1'b0;
    else        mclk_out <= ~mclk_out;

  assign ax = {1'b0, col} - (CW+1)'(HSYNC_CLKS);
  assign dx = ax - (CW+1)'(ox);
  assign dy = {1'b0, row} - (RW+1)'(oy);
  assign in_x = (col >= CW'(HSYNC_CLKS)) && (ax >= (CW+1)'(ox)) && (dx < (CW+1)'(WIN));
  assign in_y = (row >= oy) && (dy < (RW+1)'(WIN));
  assign wr_en   = armed && !fsync && in_x && in_y;
  assign wr_addr = {dy[WIN_LG-1:0], dx[WIN_LG-1:0]};

  always_ff @(posedge pix_clk or negedge rst_n)
    if (!rst_n) begin
      col   <= '0;
      row   <= '0;
      ox    <= '0;
      oy    <= '0;
      armed <= 1'b0;
    end else if (fsync) begin
      col   <= '0;
      row   <= '0;
      ox    <= org_x;
      oy    <= org_y;
      armed <= 1'b1;
    end else if (col == CW'(LINE_CLKS - 1)) begin
      col <= '0;
      if (row == RW'(FRAME_LINES - 1)) begin
        row   <= '0;
        armed <= 1'b0;
      end else begin
        row <= row + 1'b1;
      end
    end else begin
      col <= col + 1'b1;
    end

  always_ff @(posedge pix_clk or negedge rst_n)
    if (!rst_n)                  frame_done <= 1'b0;
    else if (fsync)              frame_done <= 1'b0;
    else if (wr_en && &wr_addr)  frame_done <= 1'b1;

  always_ff @(posedge pix_clk)
    if (wr_en) mem[wr_addr] <= pix_data;

  always_ff @(posedge rd_clk)
    rd_data <= mem[rd_addr];

endmodule

module swg_props #(parameter int AW = 10) (
  input logic          ref_clk,
  input logic          pix_clk,
  input logic          rst_n,
  input logic          mclk_out,
  input logic          fsync,
  input logic          frame_done,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);

  // R1
  mclk_toggle_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    rst_n |=> mclk_out != $past(mclk_out));

  // R7
  done_clear_chk: assert property (@(posedge pix_clk) disable iff (!rst_n)
    fsync |=> !frame_done);

  // R7
  done_rise_chk: assert property (@(posedge pix_clk) disable iff (!rst_n)
    $rose(frame_done) |-> $past(wr_en && (&wr_addr)));

  // R8
  no_late_write_chk: assert property (@(posedge pix_clk) disable iff (!rst_n)
    wr_en |-> !frame_done);

  // R4
  addr_step_chk: assert property (@(posedge pix_clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + AW'(1));

endmodule

bind sensor_window_grab swg_props #(.AW(2*WIN_LG)) u_props (
  .ref_clk(ref_clk), .pix_clk(pix_clk), .rst_n(rst_n), .mclk_out(mclk_out),
  .fsync(fsync), .frame_done(frame_done), .wr_en(wr_en), .wr_addr(wr_addr));

// File: tb/sim_sensor_window_grab.sv
module sim_sensor_window_grab;
  localparam int LC = 40, HS = 6, NL = 30, WL = 3, W = 8, N = 64;

  logic clk = 0, rd_clk = 0, rst_n = 0, fsync = 0;
  logic [11:0] pix_data = '0;
  logic [5:0]  org_x = '0;
  logic [4:0]  org_y = '0;
  logic [5:0]  rd_addr = '0;
  logic        mclk_out, frame_done;
  logic [11:0] rd_data;
  logic        rd_vld = 0, vd = 0, finished = 0;

  int checks = 0, fails = 0;
  logic [11:0] exp_mem [N];
  logic [11:0] sbq [$];
  string       tagq [$];

  always #5 clk = ~clk;
  initial begin #3; forever #5 rd_clk = ~rd_clk; end

  sensor_window_grab #(.LINE_CLKS(LC), .HSYNC_CLKS(HS), .FRAME_LINES(NL),
                       .SAMPLE_W(12), .WIN_LG(WL)) u0 (
    .ref_clk(clk), .rst_n(rst_n), .mclk_out(mclk_out), .pix_clk(clk),
    .fsync(fsync), .pix_data(pix_data), .org_x(org_x), .org_y(org_y),
    .frame_done(frame_done), .rd_clk(rd_clk), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] pix(int r, int c, int salt);
    logic [5:0] rr, cc;
    rr = 6'(r);
    cc = 6'(c);
    return {rr, cc} ^ 12'(salt);
  endfunction

  task automatic run_frame(int ox, int oy, int salt, int nlines, int cox, int coy);
    bit prev_last = 0;
    @(negedge clk);
    fsync = 1; org_x = 6'(ox); org_y = 5'(oy); pix_data = 12'hFFF;
    for (int r = 0; r < nlines; r++)
      for (int c = 0; c < LC; c++) begin
        bit inw, last;
        @(negedge clk);
        if (r == 0 && c == 0) check(frame_done == 0, "R7 cleared by fsync", frame_done, 0);
        if (prev_last) check(frame_done == 1, "R7 set after last sample", frame_done, 1);
        inw  = c >= HS && c - HS >= ox && c - HS - ox < W && r >= oy && r - oy < W;
        last = inw && c - HS - ox == W - 1 && r - oy == W - 1;
        if (last) check(frame_done == 0, "R7 low before last sample", frame_done, 0);
        fsync = 0;
        if (r == 2 && c == 0) begin org_x = 6'(cox); org_y = 5'(coy); end
        pix_data = pix(r, c, salt);
        if (inw) exp_mem[(r - oy) * W + c - HS - ox] = pix_data;
        prev_last = last;
      end
    if (prev_last) begin
      @(negedge clk);
      check(frame_done == 1, "R10 done at final clock", frame_done, 1);
    end
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < N; a++) begin
      @(negedge rd_clk);
      rd_addr = 6'(a); rd_vld = 1;
      sbq.push_back(exp_mem[a]); tagq.push_back(tag);
    end
    @(negedge rd_clk);
    rd_vld = 0;
    while (sbq.size() != 0) @(negedge rd_clk);
  endtask

  always @(posedge rd_clk) vd <= rd_vld;

  always @(negedge rd_clk)
    if (vd) begin
      if (sbq.size() == 0) check(0, "R9 unexpected read", rd_data, 0);
      else begin
        logic [11:0] e;
        string t;
        e = sbq.pop_front();
        t = tagq.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic m0;
    repeat (3) @(negedge clk);
    check(mclk_out == 0, "R1 reset value", mclk_out, 0);
    check(frame_done == 0, "R7 reset value", frame_done, 0);
    rst_n = 1;
    @(negedge clk);
    m0 = mclk_out;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check(mclk_out == (m0 ^ i[0]), "R1 divide by two", mclk_out, m0 ^ i[0]);
    end

    // R2 R3 R4 R5: origin at top-left of active area
    run_frame(0, 0, 0, NL, 0, 0);
    read_all("R2 R3 R4 R5 R9 origin 0,0");

    // R6: origin changed mid-frame must not move window
    run_frame(10, 5, 12'h5A5, NL, 3, 1);
    read_all("R6 origin latched at fsync");
    check(frame_done == 1, "R7 held until fsync", frame_done, 1);

    // R8: stream continues without fsync
    for (int i = 0; i < NL * LC; i++) begin
      @(negedge clk);
      pix_data = 12'(i * 37 + 5);
    end
    check(frame_done == 1, "R8 flag kept after frame", frame_done, 1);
    read_all("R8 no capture after frame end");

    // R2: aborted frame then restart by fsync
    run_frame(4, 3, 12'h333, 6, 4, 3);
    run_frame(4, 3, 12'h0C3, NL, 4, 3);
    read_all("R2 restart after mid-frame fsync");

    // R10: bottom-right corner window
    run_frame(LC - HS - W, NL - W, 12'h9E1, NL, 0, 0);
    read_all("R10 R4 bottom-right window");

    finish_run();
  end
endmodule